// File: doc/BRIEF.md
# Dual-Edge Tachometer Pulse Conditioner

This block turns a slow square-wave tachometer signal, anywhere from 5 Hz to 325 Hz, into a train of clean pulses of fixed width. It fires one pulse for every transition of the input, rising or falling, so the output runs at exactly twice the input frequency. The raw input is asynchronous to the system clock. It passes through a synchronizer chain, and a change between two successive synchronized samples counts as a transition.

A pulse lasts a fixed number of clock cycles. That count comes from the clock frequency and a pulse width given in microseconds. The default is 1400 µs, which falls inside the 2.41 ms ± 1.08 ms window. It also stays shorter than the 1.54 ms half period at the top input frequency. While a pulse is running, further transitions are dropped. This masking is what rejects contact bounce close to each real edge. Downstream logic can count or time the output directly.

Top module: `tach_doubler`

## Requirements
- R1: While rst_ni is low, pulse_o is low, whatever the clock is doing. After release with tach_i held steady, no pulse is emitted.
- R2: A rising transition of tach_i set up before clock edge k makes pulse_o go high right after edge k+2, when no pulse is active.
- R3: A falling transition of tach_i behaves the same way, with the same latency as in R2.
- R4: Every pulse on pulse_o stays high for exactly PULSE_CYCLES clock cycles.
- R5: A transition set up before edge j, following an accepted transition set up before edge k, starts a new pulse only if j − k ≥ PULSE_CYCLES + 1. Otherwise it is ignored and does not extend the running pulse.
- R6: While tach_i is steady, pulse_o never rises. Each rise comes from exactly one input transition.
- R7: PULSE_CYCLES equals CLK_FREQ_HZ × PULSE_US / 1,000,000. For example, a 1 MHz clock with 8 µs gives 8 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tach_i | input | 1 | Raw tachometer square wave, asynchronous |
| pulse_o | output | 1 | Doubled train of fixed-width pulses |

## Verification
A transition driven before a clock edge appears on the output three samples later: two synchronizer flops, then the timer flop. So a toggle driven at one falling clock edge is first seen high at the third falling edge after it. The bench drives the input and samples the output only on falling edges. It toggles the input at every half period from 1 to 20 cycles against an 8-cycle pulse. For each sweep it computes which toggles are accepted, using the spacing rule in R5, and checks every rise index, every width and the pulse count against that list. Idle windows and an asynchronous reset in the middle of a pulse are checked on the very next sample.

// File: rtl/tach_pkg.sv
package tach_pkg;
  function automatic int unsigned pulse_cycles(longint unsigned clk_hz, longint unsigned width_us);
    longint unsigned c;
    c = (clk_hz * width_us) / 64'd1_000_000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/tach_edge_det.sv
module tach_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;

  // either polarity counts
  assign edge_o = level_i ^ prev_q;
endmodule

// File: rtl/tach_pulse_timer.sv
module tach_pulse_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic busy_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (edge_i) begin
        busy_q <= 1'b1;
        cnt_q  <= LOAD;
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;

  // masked edges must not reload the timer
  assert_edge_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && busy_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_start_on_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(edge_i));
endmodule

// File: rtl/tach_doubler.sv
module tach_doubler #(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int PULSE_US    = 1400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tach_i,
  output logic pulse_o
);
  localparam int PULSE_CYCLES = tach_pkg::pulse_cycles(64'(CLK_FREQ_HZ), 64'(PULSE_US));
  localparam int HW = $clog2(PULSE_CYCLES + 2) + 1;

  logic tach_s;
  logic edge_s;

  tach_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tach_i), .q_o(tach_s)
  );

  tach_edge_det i_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(tach_s), .edge_o(edge_s)
  );

  tach_pulse_timer #(.CYCLES(PULSE_CYCLES)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_s), .busy_o(pulse_o)
  );

  // high-time tracker for width assertions
  logic [HW-1:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               hi_len_q <= '0;
    else if (!pulse_o)         hi_len_q <= '0;
    else if (hi_len_q != '1)   hi_len_q <= hi_len_q + 1'b1;

  assert_pulse_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> (hi_len_q == HW'(PULSE_CYCLES)));

  assert_no_overlong_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_len_q <= HW'(PULSE_CYCLES));

  assert_quiet_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pulse_o);

  assert_rise_needs_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(edge_s));
endmodule

// File: tb/test_tach_doubler.sv
module test_tach_doubler;
  localparam int CLK_HZ = 1_000_000;
  localparam int P_US   = 8;
  localparam int P      = CLK_HZ / 1_000_000 * P_US;  // R7: 8 cycles

  logic clk_i  = 1'b0;
  logic rst_ni = 1'b0;
  logic tach_i = 1'b0;
  logic pulse_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  tach_doubler #(.CLK_FREQ_HZ(CLK_HZ), .PULSE_US(P_US), .SYNC_STAGES(2)) i_tach_doubler (
    .clk_i(clk_i), .rst_ni(rst_ni), .tach_i(tach_i), .pulse_o(pulse_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_check(input int n, input string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (pulse_o) highs++;
    end
    chk(highs == 0, req, highs, 0);
  endtask

  // toggle every h cycles, m toggles; expected accepted toggles by spacing rule
  task automatic sweep(input int h, input int m);
    int acc_t[64];
    int n_acc = 0;
    int last  = -100000;
    int rises = 0;
    int width = 0;
    int highs = 0;
    bit prev  = 1'b0;
    bit start_lvl;
    start_lvl = tach_i;
    for (int i = 0; i < m; i++) begin
      if (i * h - last >= P + 1) begin
        acc_t[n_acc] = i * h;
        n_acc++;
        last = i * h;
      end
    end
    for (int n = 0; n < m * h + P + 8; n++) begin
      @(negedge clk_i);
      if (pulse_o) begin
        highs++;
        width++;
      end
      if (pulse_o && !prev) begin
        if (rises < n_acc) begin
          bit lvl;
          lvl = start_lvl ^ (((acc_t[rises] / h) + 1) % 2 == 1);
          if (lvl) chk(n == acc_t[rises] + 3, "R2 rise timing", n, acc_t[rises] + 3);
          else     chk(n == acc_t[rises] + 3, "R3 fall-triggered timing", n, acc_t[rises] + 3);
        end else begin
          chk(1'b0, "R5 unexpected pulse", rises + 1, n_acc);
        end
        rises++;
      end
      if (!pulse_o && prev) begin
        chk(width == P, "R4 R7 pulse width", width, P);
        width = 0;
      end
      prev = pulse_o;
      if ((n % h == 0) && (n / h < m)) tach_i = ~tach_i;
    end
    chk(rises == n_acc, "R5 pulse count", rises, n_acc);
    chk(highs == n_acc * P, "R4 total high cycles", highs, n_acc * P);
    idle_check(20, "R6 steady input");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    chk(pulse_o == 1'b0, "R1 during reset", int'(pulse_o), 0);
    rst_ni = 1'b1;
    idle_check(12, "R1 R6 after release");

    for (int h = 1; h <= 20; h++) sweep(h, 7);

    // async reset in mid-pulse
    if (tach_i) begin
      @(negedge clk_i);
      tach_i = 1'b0;
      repeat (P + 10) @(negedge clk_i);
    end
    @(negedge clk_i);
    tach_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(pulse_o == 1'b1, "R2 pulse before reset", int'(pulse_o), 1);
    #2;
    rst_ni = 1'b0;
    tach_i = 1'b0;
    #1;
    chk(pulse_o == 1'b0, "R1 async clear", int'(pulse_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle_check(20, "R1 no pulse after release");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule